// File: doc/BRIEF.md
# Partitioned Receive Element Buffer

This block sits behind a receive framer. It takes a 16-bit-per-cycle ingress stream, cuts each burst into fixed-size elements and stores them in an 8 KB RAM made of 64-bit rows. Each burst carries a class, and the class picks one of up to three partitions. Every partition draws free elements from its own range of the element index space. When an element fills, or when its burst ends, the block pushes a status word into a first-in first-out queue. The queue hands elements to the consumer in the order their data arrived.

The consumer pops status words and reads element contents one RAM row at a time through a read port. When it is done with an element, it hands the element index back through a free port. The element size and the partition count are configuration inputs. The block only takes them in while receive is disabled, and taking in a new value rebuilds every free list. Inside each 8-byte row the two 4-byte halves are stored in swapped order. Consumer software depends on that fixed lane layout.

Top module: `rx_elem_buf`

## Requirements
- R1: After reset, `st_valid`, `rd_valid`, `ovf_flag` and `free_err_flag` are 0. Every element is free, the partition count is 1 and the element size is 64 bytes.
- R2: The first byte of a beat is `in_data[15:8]` and the second is `in_data[7:0]`. The byte that arrives in position j of a row (0..7) is stored in `rd_data[8*(j^4)+7 : 8*(j^4)]`.
- R3: `cfg_size` 0, 1 and 2 select 64-, 128- and 256-byte elements; 3 acts as 2. Element i occupies rows i*(size/8) onward. When an element fills, the burst continues in the next allocated element. A status `st_count` is always even and lies between 2 and the element size.
- R4: `cfg_parts` 1, 2 and 3 select the partition count; 0 acts as 1. With N elements, one partition covers [0,N). Two partitions cover [0,N/2) and [N/2,N). Three partitions cover [0,N/2), [N/2,3N/4) and [3N/4,N). `in_class` selects the partition and is clamped to the highest partition. Allocation takes the lowest free index in that range.
- R5: A status word carries the element index, the byte count, sop (first element of its burst), eop (last element of its burst) and the partition number. Status words leave in arrival order. The head entry holds steady until it is popped.
- R6: If no element can be allocated when one is needed (no free index in the range, or the status queue is full), the rest of the burst up to its end beat is dropped and `ovf_flag` sets and stays set. No status is produced for the dropped part.
- R7: `free_valid` with an index returns that element to its free list. Freeing an index that is already free, or one at or above N, changes nothing and sets the sticky `free_err_flag`.
- R8: While `rx_enable` is 0, ingress beats are ignored and the configuration inputs are taken in. A change of configuration frees every element. While `rx_enable` is 1, configuration inputs have no effect.
- R9: A `rd_req` returns the 64-bit row `rd_row` on `rd_data`, with `rd_valid` high for exactly the next cycle.
- R10: A beat without `in_sop` that arrives outside a burst is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Receive enable; configuration loads while low |
| cfg_parts | input | 2 | Partition count (1..3, 0 acts as 1) |
| cfg_size | input | 2 | Element size code (0:64, 1:128, 2/3:256 bytes) |
| in_valid | input | 1 | Ingress beat valid |
| in_sop | input | 1 | Beat starts a burst |
| in_eop | input | 1 | Beat ends a burst |
| in_class | input | 2 | Partition selector for the burst |
| in_data | input | 16 | Two ingress bytes, first in the upper half |
| st_valid | output | 1 | Status queue not empty |
| st_pop | input | 1 | Remove the head status word |
| st_idx | output | 7 | Head status: element index |
| st_count | output | 9 | Head status: valid bytes |
| st_sop | output | 1 | Head status: first element of burst |
| st_eop | output | 1 | Head status: last element of burst |
| st_part | output | 2 | Head status: partition number |
| free_valid | input | 1 | Return an element |
| free_idx | input | 7 | Index being returned |
| rd_req | input | 1 | Row read request |
| rd_row | input | 10 | Row address |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Row contents |
| ovf_flag | output | 1 | Sticky drop flag |
| free_err_flag | output | 1 | Sticky bad-free flag |

## Verification
The bench drives bursts of 2 bytes, exactly one element, and just over one element into all three partitions, plus a class above the top partition. If the row-half swap is wrong, the row read-back fails. If the clamp is wrong, the index lands outside the partition. If element rollover is broken, the second status has the wrong index or count, or carries a stray sop. A second group of tests fills a small partition and checks what happens one burst past full. A design that wrote a partial element would report a ninth status, and a missing sticky flag would read 0. The same group changes configuration with receive enabled and then disabled. A design that took the change at the wrong time, or failed to rebuild the lists, would place the next burst at the wrong index or drop it. A double free must leave allocation order unchanged, so a corrupted free map shows up as a reused or skipped index.

// File: rtl/rxb_pkg.sv
// Shared sizes and the status word for the receive element buffer.
// Assumes a RAM made of 8-byte rows and a 64-byte smallest element.
package rxb_pkg;
    parameter int RAM_BYTES = 8192;
    parameter int ROW_BYTES = 8;
    parameter int MIN_ELEM  = 64;
    parameter int MAX_ELEM  = 256;
    localparam int ROWS      = RAM_BYTES / ROW_BYTES;
    localparam int ROW_W     = $clog2(ROWS);
    localparam int MAX_ELEMS = RAM_BYTES / MIN_ELEM;
    localparam int IDX_W     = $clog2(MAX_ELEMS);
    localparam int CNT_W     = $clog2(MAX_ELEM) + 1;
    localparam int DATA_W    = ROW_BYTES * 8;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] cnt;
        logic             sop;
        logic             eop;
        logic [1:0]       part;
    } status_t;
endpackage

// File: rtl/rxb_free_pool.sv
// Free-element bitmap with a lowest-index allocator over a [lo,hi) range.
// Assumes at most one take and one return per cycle; init frees everything.
module rxb_free_pool
    import rxb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             init,
    input  logic [IDX_W:0]   lo,
    input  logic [IDX_W:0]   hi,
    input  logic [IDX_W:0]   n_elems,
    input  logic             take,
    input  logic             ret_valid,
    input  logic [IDX_W-1:0] ret_idx,
    output logic             found,
    output logic [IDX_W-1:0] found_idx,
    output logic             ret_bad
);
    logic [MAX_ELEMS-1:0] free_map;

    // Search downward so the lowest free index in range wins.
    always_comb begin
        found     = 1'b0;
        found_idx = '0;
        for (int i = MAX_ELEMS - 1; i >= 0; i--) begin
            if (free_map[i] && ((IDX_W+1)'(i) >= lo) && ((IDX_W+1)'(i) < hi)) begin
                found     = 1'b1;
                found_idx = IDX_W'(i);
            end
        end
    end

    // A return is bad if the index is out of range or already free.
    assign ret_bad = ret_valid && (({1'b0, ret_idx} >= n_elems) || free_map[ret_idx]);

    // Bitmap maintenance: clear on take, set on a good return.
    always_ff @(posedge clk) begin
        if (!rst_n || init) begin
            free_map <= '1;
        end else begin
            if (take)
                free_map[found_idx] <= 1'b0;
            if (ret_valid && !ret_bad)
                free_map[ret_idx] <= 1'b1;
        end
    end
endmodule

// File: rtl/rxb_stat_fifo.sv
// Ordered status queue; head is shown combinationally while not empty.
// Assumes push is never asserted while full (the caller checks full).
module rxb_stat_fifo
    import rxb_pkg::*;
#(
    parameter int DEPTH = MAX_ELEMS
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    push,
    input  status_t din,
    input  logic    pop,
    output status_t dout,
    output logic    valid,
    output logic    full
);
    localparam int PW = $clog2(DEPTH);
    status_t        mem [DEPTH];
    logic [PW-1:0]  wp, rp;
    logic [PW:0]    cnt;
    logic           do_pop;

    assign valid  = (cnt != '0);
    assign full   = (cnt == (PW+1)'(DEPTH));
    assign dout   = mem[rp];
    assign do_pop = pop && valid;

    // Store pushed words.
    always_ff @(posedge clk) begin
        if (push)
            mem[wp] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (push)   wp <= wp + 1'b1;
            if (do_pop) rp <= rp + 1'b1;
            cnt <= cnt + (PW+1)'(push) - (PW+1)'(do_pop);
        end
    end
endmodule

// File: rtl/rxb_row_ram.sv
// Row RAM: 16-bit lane writes with the half-row swap, one-cycle row reads.
// Assumes lane 0..3 is the beat position inside the row in arrival order.
module rxb_row_ram
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ROW_W-1:0]  wr_row,
    input  logic [1:0]        wr_lane,
    input  logic [15:0]       wr_data,
    input  logic              rd_req,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] mem [ROWS];
    logic [5:0]        bitpos;

    // Beat b lands at byte offset (2b)^4, i.e. bit 16*(b^2); first byte lower.
    assign bitpos = {wr_lane ^ 2'd2, 4'd0};

    // Lane write.
    always_ff @(posedge clk) begin
        if (wr_en)
            mem[wr_row][bitpos +: 16] <= {wr_data[7:0], wr_data[15:8]};
    end

    // Registered row read.
    always_ff @(posedge clk) begin
        if (rd_req)
            rd_data <= mem[rd_row];
    end

    // Read valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_valid <= 1'b0;
        else        rd_valid <= rd_req;
    end
endmodule

// File: rtl/rx_elem_buf.sv
// Receive element buffer top: splits bursts into elements, allocates per
// partition, writes the RAM, and queues status in arrival order.
// Assumes a well-formed framer (sop starts a burst, eop ends it). A burst
// cut short by disabling receive leaves its element allocated.
module rx_elem_buf
    import rxb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic [1:0]        cfg_parts,
    input  logic [1:0]        cfg_size,
    input  logic              in_valid,
    input  logic              in_sop,
    input  logic              in_eop,
    input  logic [1:0]        in_class,
    input  logic [15:0]       in_data,
    output logic              st_valid,
    input  logic              st_pop,
    output logic [IDX_W-1:0]  st_idx,
    output logic [CNT_W-1:0]  st_count,
    output logic              st_sop,
    output logic              st_eop,
    output logic [1:0]        st_part,
    input  logic              free_valid,
    input  logic [IDX_W-1:0]  free_idx,
    input  logic              rd_req,
    input  logic [ROW_W-1:0]  rd_row,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic              ovf_flag,
    output logic              free_err_flag
);
    logic [1:0]       parts_q, size_q, size_eff, parts_eff, part_sel, rng_part, cur_part;
    logic [IDX_W:0]   n_elems, half, quarter, lo, hi;
    logic [CNT_W-1:0] esize, bcnt, cnt0, newcnt;
    logic [IDX_W-1:0] cur_idx, eidx, found_idx;
    logic [2:0]       shift;
    logic [ROW_W-1:0] wr_row;
    logic in_burst, have_elem, dropping, cur_first;
    logic beat, start, cont, use_new, can_new, wr_en, fail, push, sop_flag;
    logic found, fifo_full, ret_bad, init;
    status_t st_in, st_out;

    // Configuration decode and partition ranges.
    always_comb begin
        size_eff  = (size_q == 2'd3) ? 2'd2 : size_q;
        parts_eff = (parts_q == 2'd0) ? 2'd1 : parts_q;
        n_elems   = (IDX_W+1)'(MAX_ELEMS) >> size_eff;
        half      = n_elems >> 1;
        quarter   = n_elems >> 2;
        esize     = CNT_W'(MIN_ELEM) << size_eff;
        shift     = 3'd3 + {1'b0, size_eff};
        part_sel  = (in_class > parts_eff - 2'd1) ? parts_eff - 2'd1 : in_class;
        rng_part  = in_sop ? part_sel : cur_part;
        case (rng_part)
            2'd0:    begin lo = '0;             hi = (parts_eff == 2'd1) ? n_elems : half; end
            2'd1:    begin lo = half;           hi = (parts_eff == 2'd2) ? n_elems : half + quarter; end
            default: begin lo = half + quarter; hi = n_elems; end
        endcase
    end

    // Beat classification and write/allocate decisions.
    always_comb begin
        beat     = in_valid && rx_enable;
        start    = beat && in_sop;
        cont     = beat && !in_sop && in_burst && !dropping;
        use_new  = start || (cont && !have_elem);
        can_new  = found && !fifo_full;
        wr_en    = (start && can_new) || (cont && (have_elem || can_new));
        fail     = use_new && !can_new;
        eidx     = use_new ? found_idx : cur_idx;
        cnt0     = use_new ? '0 : bcnt;
        newcnt   = cnt0 + CNT_W'(2);
        push     = wr_en && ((newcnt == esize) || in_eop);
        sop_flag = start ? 1'b1 : (use_new ? 1'b0 : cur_first);
        wr_row   = (ROW_W'(eidx) << shift) | ROW_W'(cnt0 >> 3);
        init     = !rx_enable && ((cfg_parts != parts_q) || (cfg_size != size_q));
        st_in    = '{idx: eidx, cnt: newcnt, sop: sop_flag, eop: in_eop,
                     part: start ? part_sel : cur_part};
    end

    // Burst state, configuration load and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            parts_q <= 2'd1;  size_q <= 2'd0;
            in_burst <= 1'b0; have_elem <= 1'b0; dropping <= 1'b0; cur_first <= 1'b0;
            cur_idx <= '0;    bcnt <= '0;        cur_part <= '0;
            ovf_flag <= 1'b0; free_err_flag <= 1'b0;
        end else begin
            if (!rx_enable) begin
                parts_q  <= cfg_parts;
                size_q   <= cfg_size;
                in_burst <= 1'b0;
                dropping <= 1'b0;
            end
            if (wr_en) begin
                cur_idx   <= eidx;
                bcnt      <= newcnt;
                have_elem <= !push;
                cur_first <= sop_flag;
                in_burst  <= !in_eop;
                dropping  <= 1'b0;
                if (start) cur_part <= part_sel;
            end else if (fail) begin
                in_burst  <= !in_eop;
                dropping  <= !in_eop;
                have_elem <= 1'b0;
                ovf_flag  <= 1'b1;
                if (start) cur_part <= part_sel;
            end else if (beat && in_burst && dropping && in_eop) begin
                in_burst <= 1'b0;
                dropping <= 1'b0;
            end
            if (ret_bad) free_err_flag <= 1'b1;
        end
    end

    rxb_free_pool pool_i (
        .clk(clk), .rst_n(rst_n), .init(init), .lo(lo), .hi(hi), .n_elems(n_elems),
        .take(wr_en && use_new), .ret_valid(free_valid), .ret_idx(free_idx),
        .found(found), .found_idx(found_idx), .ret_bad(ret_bad)
    );

    rxb_stat_fifo #(.DEPTH(MAX_ELEMS)) fifo_i (
        .clk(clk), .rst_n(rst_n), .push(push), .din(st_in), .pop(st_pop),
        .dout(st_out), .valid(st_valid), .full(fifo_full)
    );

    rxb_row_ram ram_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row), .wr_lane(cnt0[2:1]),
        .wr_data(in_data), .rd_req(rd_req), .rd_row(rd_row), .rd_valid(rd_valid),
        .rd_data(rd_data)
    );

    assign st_idx   = st_out.idx;
    assign st_count = st_out.cnt;
    assign st_sop   = st_out.sop;
    assign st_eop   = st_out.eop;
    assign st_part  = st_out.part;
endmodule

// File: rtl/rx_elem_buf_chk.sv
// Property checker for rx_elem_buf, attached by bind.
module rx_elem_buf_chk
    import rxb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             rd_valid,
    input logic             st_valid,
    input logic             st_pop,
    input logic [IDX_W-1:0] st_idx,
    input logic [CNT_W-1:0] st_count,
    input logic             ovf_flag,
    input logic             free_err_flag
);
    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

    assert_free_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        free_err_flag |=> free_err_flag);

    assert_rd_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_valid);

    assert_rd_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> !rd_valid);

    assert_head_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && !st_pop) |=> (st_valid && $stable(st_idx) && $stable(st_count)));

    assert_count_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_valid |-> (st_count != '0 && st_count <= CNT_W'(MAX_ELEM) && !st_count[0]));
endmodule

bind rx_elem_buf rx_elem_buf_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_valid(rd_valid),
    .st_valid(st_valid), .st_pop(st_pop), .st_idx(st_idx), .st_count(st_count),
    .ovf_flag(ovf_flag), .free_err_flag(free_err_flag)
);

// File: tb/rx_elem_buf_tb_top.sv
// Self-checking bench for rx_elem_buf: a vector table of bursts, then
// directed tests for reset, overflow, configuration and freeing.
module rx_elem_buf_tb_top;
    logic clk = 1'b0, rst_n = 1'b0, rx_enable = 1'b0;
    logic [1:0] cfg_parts = 2'd3, cfg_size = 2'd0, in_class = 2'd0;
    logic in_valid = 0, in_sop = 0, in_eop = 0, st_pop = 0, free_valid = 0, rd_req = 0;
    logic [15:0] in_data = '0;
    logic [6:0] free_idx = '0;
    logic [9:0] rd_row = '0;
    logic st_valid, st_sop, st_eop, rd_valid, ovf_flag, free_err_flag;
    logic [6:0] st_idx;
    logic [8:0] st_count;
    logic [1:0] st_part;
    logic [63:0] rd_data;
    int checks = 0, errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    rx_elem_buf dut_i (.*);

    // Vector: {class[1:0], beats[7:0], first index[6:0]}; 3 partitions, 64 B elements.
    localparam logic [16:0] VEC [6] = '{
        {2'd0, 8'd5,  7'd0},
        {2'd1, 8'd32, 7'd64},
        {2'd2, 8'd40, 7'd96},
        {2'd3, 8'd4,  7'd96},
        {2'd0, 8'd33, 7'd0},
        {2'd1, 8'd1,  7'd64}
    };

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(int j, int seed);
        return 8'((j + seed) & 255);
    endfunction

    task automatic send_burst(logic [1:0] cls, int beats, int seed);
        for (int b = 0; b < beats; b++) begin
            @(negedge clk);
            in_valid = 1; in_class = cls;
            in_sop = (b == 0); in_eop = (b == beats - 1);
            in_data = {bval(2*b, seed), bval(2*b + 1, seed)};
        end
        @(negedge clk);
        in_valid = 0; in_sop = 0; in_eop = 0;
    endtask

    task automatic pop_check(string req, int idx, int cnt, bit sop, bit eop, int part);
        check(req, st_valid, 1);
        check(req, st_idx, idx);
        check(req, st_count, cnt);
        check(req, {st_sop, st_eop}, {sop, eop});
        check(req, st_part, part);
        st_pop = 1;
        @(negedge clk);
        st_pop = 0;
    endtask

    task automatic read_row(int row, output logic [63:0] data);
        rd_req = 1; rd_row = 10'(row);
        @(negedge clk);
        rd_req = 0;
        check("R9 rd_valid high", rd_valid, 1);
        data = rd_data;
        @(negedge clk);
        check("R9 rd_valid drops", rd_valid, 0);
    endtask

    task automatic free_el(int idx);
        @(negedge clk);
        free_valid = 1; free_idx = 7'(idx);
        @(negedge clk);
        free_valid = 0;
    endtask

    // Main sequence.
    initial begin
        logic [63:0] row, exp;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 st_valid", st_valid, 0);
        check("R1 flags", {ovf_flag, free_err_flag, rd_valid}, 0);
        rx_enable = 1;
        @(negedge clk);

        foreach (VEC[v]) begin
            int cls = VEC[v][16:15], beats = VEC[v][14:7], lo = VEC[v][6:0];
            int seed = v * 16, bytes = 2 * beats, nel = (2 * beats + 63) / 64;
            int part = (cls > 2) ? 2 : cls;
            send_burst(2'(cls), beats, seed);
            for (int k = 0; k < nel; k++) begin
                int cnt = (k < nel - 1) ? 64 : bytes - 64 * (nel - 1);
                pop_check("R5 R3 R4 status", lo + k, cnt, k == 0, k == nel - 1, part);
            end
            check("R5 queue empty", st_valid, 0);
            for (int k = 0; k < nel && k < 2; k++) begin
                if (bytes >= 64 * k + 8) begin
                    read_row((lo + k) * 8, row);
                    for (int o = 0; o < 8; o++) exp[8*o +: 8] = bval(64 * k + (o ^ 4), seed);
                    check("R2 R3 row layout", row, exp);
                end
            end
            for (int k = 0; k < nel; k++) free_el(lo + k);
        end

        // R8: beats ignored while disabled; then load 256 B elements, 3 partitions.
        @(negedge clk);
        rx_enable = 0;
        send_burst(2'd0, 3, 0);
        check("R8 disabled ingress ignored", st_valid, 0);
        cfg_size = 2'd2;
        @(negedge clk);
        rx_enable = 1;
        // R10: stray beat outside a burst.
        @(negedge clk);
        in_valid = 1; in_sop = 0; in_eop = 1; in_data = 16'hABCD;
        @(negedge clk);
        in_valid = 0; in_eop = 0;
        @(negedge clk);
        check("R10 stray beat ignored", st_valid, 0);

        // R6: partition 2 is [24,32): 8 elements, then a drop.
        for (int i = 0; i < 8; i++) send_burst(2'd2, 1, i);
        check("R6 no overflow yet", ovf_flag, 0);
        send_burst(2'd2, 3, 0);
        check("R6 overflow sticky", ovf_flag, 1);
        for (int i = 0; i < 8; i++) pop_check("R6 R4 fill order", 24 + i, 2, 1, 1, 2);
        check("R6 dropped burst not reported", st_valid, 0);

        // R8: configuration change ignored while enabled.
        cfg_size = 2'd0;
        send_burst(2'd1, 1, 0);
        pop_check("R8 config held while enabled", 16, 2, 1, 1, 1);
        free_el(16);

        // R8: change while disabled rebuilds the free lists.
        @(negedge clk); rx_enable = 0;
        @(negedge clk); rx_enable = 1;
        @(negedge clk); rx_enable = 0; cfg_size = 2'd2;
        @(negedge clk); rx_enable = 1;
        send_burst(2'd2, 1, 0);
        pop_check("R8 reinit frees all", 24, 2, 1, 1, 2);

        // R7: good free, then double free is ignored and flagged.
        free_el(24);
        check("R7 good free no error", free_err_flag, 0);
        free_el(24);
        check("R7 double free flagged", free_err_flag, 1);
        send_burst(2'd2, 1, 0);
        send_burst(2'd2, 1, 0);
        pop_check("R7 double free no effect", 24, 2, 1, 1, 2);
        pop_check("R7 double free no effect", 25, 2, 1, 1, 2);
        free_el(40);
        check("R7 out of range flag", free_err_flag, 1);
        done = 1;
    end

    // Finish or watchdog.
    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule